// File: doc/BRIEF.md
# Codec Wake Event and PME Logic

This block watches the serial data lines that come back from the audio codecs while the codec link is powered down. In that state the bit clock is held low and the link carries no frames. A codec that wants attention raises its data line, and the block turns that rising edge into a wake event. Wake events and a pulse from an external inactivity timer feed one power-management event status bit. That bit drives an active-low PME pin while PME signalling is enabled, and it stays set until software writes a one to clear it.

Software reaches the block through two write ports. The first is a configuration byte, which holds one wake enable per codec line, a timer-to-PME enable and a software reset bit. The second is a control/status halfword, which holds the PME enable and the write-one-to-clear status bit. Before any edge detection, the codec data lines, the power-down flag and the bit clock pass through a multi-stage synchronizer.

The status logic is a two-state machine. ST_IDLE means no event is pending. Its transition IDLE→PENDING is taken on a qualified wake edge or on an enabled timer pulse. ST_PENDING means the status bit is set. Its transition PENDING→IDLE is taken on a clear request, but only when no new event arrives in the same cycle. In every other case the state holds.

Top module: `codec_wake_pme`

## Requirements
- R1: After hardware reset (rst_n low), pme_status and wake_event are 0, pme_n is 1, and cfg_rdata is 0x00.
- R2: Configuration bits 2 (software reset), 4 (wake enable, line 0), 5 (wake enable, line 1) and 7 (timer PME enable) are written by cfg_wr and read back on cfg_rdata in the cycle after the write. All other bits read as 0.
- R3: A configuration write with bit 2 set clears both wake enables, whatever value is written in bits 4 and 5. Bits 2 and 7 take the written value.
- R4: A rising edge on codec_sdin[0], with bit 4 set, codec_pd at 1 and bit_clk at 0, sets wake_event and pme_status. This happens at the third rising clock edge after the line changes, and not before.
- R5: The same holds for codec_sdin[1] with bit 5 set.
- R6: A rising edge on a line whose wake enable is 0 leaves pme_status and wake_event at 0.
- R7: A rising edge while bit_clk is 1, or while codec_pd is 0, is ignored.
- R8: Only a 0→1 transition that is seen while the window is open counts. A line that is already high when the window opens, or a falling edge, is ignored.
- R9: A one-cycle timer_expired pulse sets pme_status at the next clock edge when bit 7 is 1, and leaves wake_event at 0. When bit 7 is 0, the pulse is ignored.
- R10: pme_status and wake_event stay set until a csr_wr with csr_wdata[15]=1. A write with bit 15 at 0 does not clear them. The clear takes effect at the edge that samples the write.
- R11: If a wake edge or an enabled timer pulse coincides with a clear request, pme_status stays set.
- R12: Every csr_wr loads the PME enable from csr_wdata[8]. pme_n is 0 exactly when pme_status and the PME enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write data |
| cfg_rdata | output | 8 | Configuration byte read-back |
| csr_wr | input | 1 | Control/status write strobe |
| csr_wdata | input | 16 | Control/status write data (bit 15 clear, bit 8 PME enable) |
| codec_pd | input | 1 | Codec link powered down |
| bit_clk | input | 1 | Codec bit clock |
| codec_sdin | input | NUM_LANES | Codec serial data lines |
| timer_expired | input | 1 | Inactivity timer expiry pulse |
| pme_status | output | 1 | PME status bit |
| wake_event | output | 1 | Sticky wake event flag |
| pme_n | output | 1 | PME pin, active low |

## Verification
The bench builds the block with NUM_LANES=2 and SYNC_STAGES=2. These are the two codec lines that the configuration byte has enable bits for, and the shortest synchronizer. With them, the three-cycle path from a line change to the status bit can be checked to the exact edge, and the check before that edge shows nothing leaks early. Both lines can be exercised against their own enables, which brings the disabled-lane and software-reset cases within reach. With two stages the power-down flag and the bit clock settle quickly, so the closed-window cases (clock high, link up, line already high, falling edge) each fit in a few cycles.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
    localparam int CFG_W          = 8;
    localparam int CSR_W          = 16;
    localparam int CFG_SWRST_BIT  = 2;
    localparam int CFG_WAKE_BASE  = 4;
    localparam int CFG_TMR_BIT    = 7;
    localparam int CSR_PMEEN_BIT  = 8;
    localparam int CSR_STATUS_BIT = 15;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } pme_state_e;
endpackage

// File: rtl/cwp_sync.sv
module cwp_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/cwp_cfg.sv
module cwp_cfg
    import cwp_pkg::*;
#(
    parameter int NUM_LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CFG_W-1:0]     wdata,
    output logic [NUM_LANES-1:0] wake_en,
    output logic                 tmr_en,
    output logic [CFG_W-1:0]     rdata
);
    logic [NUM_LANES-1:0] en_q;
    logic                 tmr_q;
    logic                 swrst_q;
    logic                 unused_wbits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= '0;
            tmr_q   <= 1'b0;
            swrst_q <= 1'b0;
        end else if (wr) begin
            swrst_q <= wdata[CFG_SWRST_BIT];
            tmr_q   <= wdata[CFG_TMR_BIT];
            en_q    <= wdata[CFG_SWRST_BIT] ? '0
                                            : wdata[CFG_WAKE_BASE +: NUM_LANES];
        end
    end

    always_comb begin
        rdata                                = '0;
        rdata[CFG_SWRST_BIT]                 = swrst_q;
        rdata[CFG_TMR_BIT]                   = tmr_q;
        rdata[CFG_WAKE_BASE +: NUM_LANES]    = en_q;
    end

    assign wake_en      = en_q;
    assign tmr_en       = tmr_q;
    assign unused_wbits = ^wdata;

    assert_swrst_clears_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[CFG_SWRST_BIT]) |=> (wake_en == '0));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(rdata));
endmodule

// File: rtl/cwp_pme_fsm.sv
module cwp_pme_fsm
    import cwp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wake_hit,
    input  logic timer_hit,
    input  logic clr_req,
    output logic status,
    output logic wake_flag
);
    pme_state_e state_q, state_d;
    logic       any_event;
    logic       clr_ok;

    assign any_event = wake_hit | timer_hit;
    assign clr_ok    = clr_req & ~any_event;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (any_event) state_d = ST_PENDING;
            ST_PENDING: if (clr_ok)    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wake_flag <= 1'b0;
        else if (wake_hit) wake_flag <= 1'b1;
        else if (clr_ok)   wake_flag <= 1'b0;
    end

    always_comb begin
        status = (state_q == ST_PENDING);
    end

    assert_status_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_req) |=> status);

    assert_clear_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status && clr_req && !wake_hit && !timer_hit) |=> !status);

    assert_event_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && (wake_hit || timer_hit)) |=> status);

    assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> $past(wake_hit || timer_hit));
endmodule

// File: rtl/codec_wake_pme.sv
module codec_wake_pme
    import cwp_pkg::*;
#(
    parameter int NUM_LANES   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 csr_wr,
    input  logic [CSR_W-1:0]     csr_wdata,
    input  logic                 codec_pd,
    input  logic                 bit_clk,
    input  logic [NUM_LANES-1:0] codec_sdin,
    input  logic                 timer_expired,
    output logic                 pme_status,
    output logic                 wake_event,
    output logic                 pme_n
);
    localparam int SW = NUM_LANES + 2;

    logic [SW-1:0]        sync_q;
    logic [NUM_LANES-1:0] sdin_s, sdin_prev, lane_hit;
    logic [NUM_LANES-1:0] wake_en;
    logic                 pd_s, bclk_s, window;
    logic                 tmr_en, wake_hit, timer_hit, clr_req;
    logic                 pme_en_q;
    logic                 unused_csr;

    cwp_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bit_clk, codec_pd, codec_sdin}),
        .q     (sync_q)
    );

    assign sdin_s = sync_q[NUM_LANES-1:0];
    assign pd_s   = sync_q[NUM_LANES];
    assign bclk_s = sync_q[NUM_LANES+1];
    assign window = pd_s & ~bclk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sdin_prev <= '0;
        else        sdin_prev <= sdin_s;
    end

    generate
        for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
            assign lane_hit[g] = wake_en[g] & sdin_s[g] & ~sdin_prev[g];
        end
    endgenerate

    assign wake_hit  = window & (|lane_hit);
    assign timer_hit = timer_expired & tmr_en;
    assign clr_req   = csr_wr & csr_wdata[CSR_STATUS_BIT];

    cwp_cfg #(.NUM_LANES(NUM_LANES)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .wake_en (wake_en),
        .tmr_en  (tmr_en),
        .rdata   (cfg_rdata)
    );

    cwp_pme_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_hit  (wake_hit),
        .timer_hit (timer_hit),
        .clr_req   (clr_req),
        .status    (pme_status),
        .wake_flag (wake_event)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pme_en_q <= 1'b0;
        else if (csr_wr) pme_en_q <= csr_wdata[CSR_PMEEN_BIT];
    end

    assign pme_n      = ~(pme_status & pme_en_q);
    assign unused_csr = ^csr_wdata;

    assert_wake_needs_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_event) |-> $past(window));

    assert_timer_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_expired && !tmr_en && !wake_hit && !pme_status) |=> !pme_status);

    assert_pin_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_status |-> pme_n);
endmodule

// File: tb/tb_codec_wake_pme.sv
`timescale 1ns/1ps
module tb_codec_wake_pme;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        csr_wr = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic        codec_pd = 1'b0;
    logic        bit_clk = 1'b0;
    logic [1:0]  codec_sdin = '0;
    logic        timer_expired = 1'b0;
    logic        pme_status, wake_event, pme_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string      req;
        logic       st;
        logic       wk;
        logic       pn;
        logic [7:0] rd;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    codec_wake_pme #(.NUM_LANES(2), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .codec_pd(codec_pd), .bit_clk(bit_clk), .codec_sdin(codec_sdin),
        .timer_expired(timer_expired), .pme_status(pme_status),
        .wake_event(wake_event), .pme_n(pme_n)
    );

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (pme_status !== e.st || wake_event !== e.wk ||
                    pme_n !== e.pn || cfg_rdata !== e.rd) begin
                    errors++;
                    $display("FAIL %s: got st=%b wk=%b pn=%b rd=%h exp st=%b wk=%b pn=%b rd=%h",
                             e.req, pme_status, wake_event, pme_n, cfg_rdata,
                             e.st, e.wk, e.pn, e.rd);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input string req, input logic st, input logic wk,
                              input logic pn, input logic [7:0] rd);
        exp_t e;
        e.req = req; e.st = st; e.wk = wk; e.pn = pn; e.rd = rd;
        sb.push_back(e);
    endtask

    task automatic cfg_write(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic csr_write(input logic [15:0] d);
        csr_wr = 1'b1; csr_wdata = d;
        step(1);
        csr_wr = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        expect_now("R1 reset", 0, 0, 1, 8'h00);

        cfg_write(8'hB4);
        expect_now("R3 swrst clears enables", 0, 0, 1, 8'h84);
        cfg_write(8'hFB);
        expect_now("R2 readback", 0, 0, 1, 8'hB0);
        csr_write(16'h0100);
        expect_now("R12 enable only", 0, 0, 1, 8'hB0);

        codec_pd = 1'b1; bit_clk = 1'b0;
        step(4);
        codec_sdin[0] = 1'b1;
        step(2);
        expect_now("R4 not before third edge", 0, 0, 1, 8'hB0);
        step(1);
        expect_now("R4 lane0 wake", 1, 1, 0, 8'hB0);
        codec_sdin[0] = 1'b0;
        step(4);
        expect_now("R10 sticky", 1, 1, 0, 8'hB0);
        csr_write(16'h0100);
        expect_now("R10 bit15 zero keeps", 1, 1, 0, 8'hB0);
        csr_write(16'h8100);
        expect_now("R10 clear", 0, 0, 1, 8'hB0);

        codec_sdin[1] = 1'b1;
        step(3);
        expect_now("R5 lane1 wake", 1, 1, 0, 8'hB0);
        codec_sdin[1] = 1'b0;
        csr_write(16'h8100);
        step(3);

        cfg_write(8'h90);
        codec_sdin[1] = 1'b1;
        step(5);
        expect_now("R6 disabled lane", 0, 0, 1, 8'h90);
        codec_sdin[1] = 1'b0;
        step(3);

        bit_clk = 1'b1; step(4);
        codec_sdin[0] = 1'b1; step(5);
        expect_now("R7 bit clock high", 0, 0, 1, 8'h90);
        codec_sdin[0] = 1'b0; step(4);
        bit_clk = 1'b0; codec_pd = 1'b0; step(4);
        codec_sdin[0] = 1'b1; step(5);
        expect_now("R7 link powered", 0, 0, 1, 8'h90);
        codec_pd = 1'b1; step(5);
        expect_now("R8 already high", 0, 0, 1, 8'h90);
        codec_sdin[0] = 1'b0; step(5);
        expect_now("R8 falling edge", 0, 0, 1, 8'h90);

        timer_expired = 1'b1; step(1); timer_expired = 1'b0;
        expect_now("R9 timer sets", 1, 0, 0, 8'h90);
        csr_write(16'h8100);
        expect_now("R10 clear after timer", 0, 0, 1, 8'h90);
        cfg_write(8'h10);
        timer_expired = 1'b1; step(1); timer_expired = 1'b0;
        step(1);
        expect_now("R9 timer gated", 0, 0, 1, 8'h10);

        csr_write(16'h0000);
        codec_sdin[0] = 1'b1; step(3);
        expect_now("R12 pin off when disabled", 1, 1, 1, 8'h10);
        codec_sdin[0] = 1'b0;
        csr_write(16'h0100);
        expect_now("R12 pin on", 1, 1, 0, 8'h10);

        cfg_write(8'h90);
        csr_wr = 1'b1; csr_wdata = 16'h8100; timer_expired = 1'b1;
        step(1);
        csr_wr = 1'b0; timer_expired = 1'b0;
        expect_now("R11 event beats clear", 1, 1, 0, 8'h90);
        csr_write(16'h8100);
        expect_now("R11 later clear", 0, 0, 1, 8'h90);

        cfg_write(8'h04);
        expect_now("R3 swrst level", 0, 0, 1, 8'h04);
        cfg_write(8'hB0);
        timer_expired = 1'b1; step(1); timer_expired = 1'b0;
        rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
        expect_now("R1 reset mid-run", 0, 0, 1, 8'h00);

        step(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule